// File: doc/BRIEF.md
# Voice Channel Register Decoder

This block is the register front end of a 64-voice sample-playback engine. A host writes 32-bit words into one of two address windows of 32 voices each. The block splits the address into a voice index and a register offset, and updates that voice's stored state. The state held for each voice is the sample start address, the loop enable, the sample format, the loop start, the end address, the playback rate, the pan position and the volume.

Two fields are converted before they are stored. The pitch word is a small floating-point number, and it is turned into an integer sample rate in Hz. The volume index goes through a monotonic loudness curve. A write to the configuration word can also fire a key-on or key-off strobe for the addressed voice.

The stored state of any voice is read back combinationally through a voice-select port. Updates become visible on that port one clock after the write.

Top module: `voice_reg_decoder`

## Requirements
- R1: The addressed voice is `wr_win*32 + wr_addr[11:7]`, and the register offset is `wr_addr[6:0]`. Window 1 therefore reaches voices 32 to 63.
- R2: Only `wr_data[15:0]` takes part in any update. Bits 31:16 have no effect.
- R3: A write at offset 0x00 stores data bits 4:0 as start-address bits 20:16 and data bit 9 as the loop enable. It also stores data bits 8:7 as the format: 0 gives code 0 (16-bit), 1 gives code 1 (8-bit), and 2 or 3 give code 2 (ADPCM). Start-address bits 15:0 are kept.
- R4: A write at offset 0x00 with data bits 15:14 equal to 3 raises `key_on` for exactly the one cycle after the write edge. The value 2 raises `key_off` in the same way. Values 0 and 1 raise neither. `key_voice` carries the voice index while a strobe is high.
- R5: A write at offset 0x04 stores start-address bits 15:0 and keeps bits 20:16. A write at offset 0x08 stores the loop start, and a write at offset 0x0C stores the end address.
- R6: A write at offset 0x18 with data bit 14 clear stores a rate, using m = bits 9:0 and e = bits 13:11. The rate is `(44100<<e) + ((44100*m)>>(10-e))`.
- R7: A write at offset 0x18 with data bit 14 set uses k = 8-e. It stores the rate `(44100>>k) + ((44100*m)>>(10+k))`. Data bits 10 and 15 are ignored.
- R8: A write at offset 0x24 takes v = data bits 4:0. It stores a pan of 15-v when v is 15 or less, and v otherwise.
- R9: A write at offset 0x28 takes i = data bits 7:0 and stores a volume of `(i*(i+1))>>8`. This gives 0 at i=0, 255 at i=255, and never decreases.
- R10: A write to any other offset changes no voice state and raises no strobe.
- R11: After reset, every field of every voice reads 0 and both strobes are low.
- R12: A written field is visible on the read port in the cycle after the write edge. No other voice changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_win | input | 1 | Window select (0: voices 0-31, 1: voices 32-63) |
| wr_addr | input | 12 | Byte address within the window |
| wr_data | input | 32 | Write data, low 16 bits used |
| rd_voice | input | 6 | Voice selected for readback |
| rd_start | output | 21 | Sample start address |
| rd_loop_en | output | 1 | Loop enable |
| rd_fmt | output | 2 | Format code (0: 16-bit, 1: 8-bit, 2: ADPCM) |
| rd_loop_start | output | 16 | Loop start |
| rd_end | output | 16 | End address |
| rd_rate | output | 32 | Sample rate in Hz |
| rd_pan | output | 5 | Pan position 0..31 |
| rd_vol | output | 8 | Volume after the loudness curve |
| key_on | output | 1 | Key-on strobe |
| key_off | output | 1 | Key-off strobe |
| key_voice | output | 6 | Voice index of the strobe |

## Verification
The bench writes one voice in window 1 and checks the voice with the same slot in window 0. A decoder that drops the window bit would overwrite the wrong voice there. It splits the start address over two writes in both orders, which catches a configuration write that clears the low half or a low-half write that clears bits 20:16.

Pitch words are taken at both exponent extremes with the sign bit set and clear. A wrong shift direction or a missed `8-e` step shows up as rates that are off by powers of two. Pan is probed at 15 and 16, where the remap changes over, and volume at both ends of its curve.

Key strobes are checked for their length, for the codes 0 and 1, and for a key code written to an offset other than 0x00. A design that holds the strobe, or that decodes the key bits at every offset, is reported.

// File: rtl/vrd_pkg.sv
package vrd_pkg;

   localparam int HALF_W   = 16;
   localparam int START_W  = 21;
   localparam int PAN_W    = 5;
   localparam int VOL_W    = 8;
   localparam int RATE_W   = 32;

   // register offsets inside one voice slot
   localparam int OFS_CFG      = 'h00;
   localparam int OFS_START_LO = 'h04;
   localparam int OFS_LOOP     = 'h08;
   localparam int OFS_END      = 'h0C;
   localparam int OFS_PITCH    = 'h18;
   localparam int OFS_PAN      = 'h24;
   localparam int OFS_VOL      = 'h28;

   typedef enum logic [1:0] {
      FMT_PCM16 = 2'd0,
      FMT_PCM8  = 2'd1,
      FMT_ADPCM = 2'd2
   } vrd_fmt_e;

   typedef enum logic [2:0] {
      FLD_NONE,
      FLD_CFG,
      FLD_START_LO,
      FLD_LOOP,
      FLD_END,
      FLD_PITCH,
      FLD_PAN,
      FLD_VOL
   } vrd_fld_e;

   typedef struct packed {
      logic [START_W-1:0] start;
      logic               loop_en;
      vrd_fmt_e           fmt;
      logic [HALF_W-1:0]  loop_start;
      logic [HALF_W-1:0]  end_addr;
      logic [RATE_W-1:0]  rate;
      logic [PAN_W-1:0]   pan;
      logic [VOL_W-1:0]   vol;
   } vrd_voice_t;

endpackage

// File: rtl/vrd_addr_decode.sv
module vrd_addr_decode
   import vrd_pkg::*;
#(
   parameter int SLOT_W = 5,
   parameter int OFS_W  = 7,
   parameter int WIN_W  = 1,
   localparam int ADDR_W = SLOT_W + OFS_W,
   localparam int VIDX_W = WIN_W + SLOT_W
) (
   input  logic [WIN_W-1:0]  win,
   input  logic [ADDR_W-1:0] addr,
   output logic [VIDX_W-1:0] voice,
   output vrd_fld_e          fld
);

   logic [OFS_W-1:0] ofs;

   assign ofs   = addr[OFS_W-1:0];
   // window bits sit above the slot bits: win*2^SLOT_W + slot
   assign voice = {win, addr[ADDR_W-1:OFS_W]};

   always_comb begin
      unique case (ofs)
         OFS_W'(OFS_CFG):      fld = FLD_CFG;
         OFS_W'(OFS_START_LO): fld = FLD_START_LO;
         OFS_W'(OFS_LOOP):     fld = FLD_LOOP;
         OFS_W'(OFS_END):      fld = FLD_END;
         OFS_W'(OFS_PITCH):    fld = FLD_PITCH;
         OFS_W'(OFS_PAN):      fld = FLD_PAN;
         OFS_W'(OFS_VOL):      fld = FLD_VOL;
         default:              fld = FLD_NONE;
      endcase
   end

endmodule

// File: rtl/vrd_pitch_conv.sv
module vrd_pitch_conv
   import vrd_pkg::*;
#(
   parameter int BASE_RATE = 44100,
   parameter int MANT_W    = 10,
   parameter int EXP_W     = 3
) (
   input  logic [HALF_W-1:0] pitch,
   output logic [RATE_W-1:0] rate
);

   localparam logic [RATE_W-1:0] BASE_V = RATE_W'(BASE_RATE);
   localparam int                SH_W   = 5;
   localparam int                EXP_LO = MANT_W + 1;
   localparam int                SIGN_B = EXP_LO + EXP_W;

   logic [MANT_W-1:0] mant;
   logic [EXP_W-1:0]  expo;
   logic              neg;
   logic [RATE_W-1:0] prod;
   logic [SH_W-1:0]   k;
   logic              unused_bits;

   assign mant = pitch[MANT_W-1:0];
   assign expo = pitch[SIGN_B-1:EXP_LO];
   assign neg  = pitch[SIGN_B];
   assign prod = BASE_V * RATE_W'(mant);
   assign k    = SH_W'(1 << EXP_W) - SH_W'(expo);
   assign unused_bits = pitch[MANT_W] ^ (^pitch[HALF_W-1:SIGN_B+1]);

   always_comb begin
      if (neg) begin
         rate = (BASE_V >> k) + (prod >> (SH_W'(MANT_W) + k));
      end else begin
         rate = (BASE_V << expo) + (prod >> (SH_W'(MANT_W) - SH_W'(expo)));
      end
   end

   // the integer part alone bounds the result on each side of the base rate
   always_comb begin
      if (!$isunknown(pitch)) begin
         if (!neg) begin
            p_rate_floor_r6 : assert (rate >= (BASE_V << expo));
         end else begin
            p_rate_below_r7 : assert (rate < BASE_V);
         end
      end
   end

endmodule

// File: rtl/vrd_vol_curve.sv
module vrd_vol_curve
   import vrd_pkg::*;
#(
   parameter int IDX_W = 8,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic [IDX_W-1:0] idx,
   output logic [VOL_W-1:0] vol
);

   logic [VOL_W-1:0] curve [DEPTH];

   // square-law curve: entry i = i*(i+1) / DEPTH, spans 0..DEPTH-1
   for (genvar i = 0; i < DEPTH; i++) begin : g_curve
      assign curve[i] = VOL_W'((i * (i + 1)) >> IDX_W);
   end

   assign vol = curve[idx];

   always_comb begin
      if (!$isunknown(idx) && idx != '0) begin
         p_vol_monotonic_r9 : assert (curve[idx] >= curve[idx - 1'b1]);
      end
   end

endmodule

// File: rtl/vrd_voice_bank.sv
module vrd_voice_bank
   import vrd_pkg::*;
#(
   parameter int VIDX_W = 6,
   localparam int NUM_VOICES = 1 << VIDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  vrd_fld_e          fld,
   input  logic [VIDX_W-1:0] widx,
   input  logic [HALF_W-1:0] wdata,
   input  logic [RATE_W-1:0] rate_in,
   input  logic [PAN_W-1:0]  pan_in,
   input  logic [VOL_W-1:0]  vol_in,
   input  logic [VIDX_W-1:0] ridx,
   output vrd_voice_t        rdata
);

   localparam int HI_LSB = HALF_W;

   vrd_voice_t mem [NUM_VOICES];
   vrd_fmt_e   fmt_dec;

   always_comb begin
      unique case (wdata[8:7])
         2'd0:    fmt_dec = FMT_PCM16;
         2'd1:    fmt_dec = FMT_PCM8;
         default: fmt_dec = FMT_ADPCM;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int v = 0; v < NUM_VOICES; v++) begin
            mem[v] <= '0;
         end
      end else if (we) begin
         unique case (fld)
            FLD_CFG: begin
               mem[widx].start[START_W-1:HI_LSB] <= wdata[START_W-HI_LSB-1:0];
               mem[widx].loop_en                 <= wdata[9];
               mem[widx].fmt                     <= fmt_dec;
            end
            FLD_START_LO: mem[widx].start[HI_LSB-1:0] <= wdata;
            FLD_LOOP:     mem[widx].loop_start        <= wdata;
            FLD_END:      mem[widx].end_addr          <= wdata;
            FLD_PITCH:    mem[widx].rate              <= rate_in;
            FLD_PAN:      mem[widx].pan               <= pan_in;
            FLD_VOL:      mem[widx].vol               <= vol_in;
            default: ;
         endcase
      end
   end

   assign rdata = mem[ridx];

   // a write to an unmapped offset leaves the viewed voice untouched
   p_ignore_unlisted_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (we && fld == FLD_NONE) |=> (!$stable(ridx) || $stable(rdata)));

   // with no write at all, the viewed voice holds its value
   p_hold_idle_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> (!$stable(ridx) || $stable(rdata)));

endmodule

// File: rtl/voice_reg_decoder.sv
module voice_reg_decoder
   import vrd_pkg::*;
#(
   parameter int SLOT_W    = 5,
   parameter int OFS_W     = 7,
   parameter int WIN_W     = 1,
   parameter int BASE_RATE = 44100,
   localparam int ADDR_W = SLOT_W + OFS_W,
   localparam int VIDX_W = WIN_W + SLOT_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [WIN_W-1:0]     wr_win,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [31:0]          wr_data,
   input  logic [VIDX_W-1:0]    rd_voice,
   output logic [START_W-1:0]   rd_start,
   output logic                 rd_loop_en,
   output logic [1:0]           rd_fmt,
   output logic [HALF_W-1:0]    rd_loop_start,
   output logic [HALF_W-1:0]    rd_end,
   output logic [RATE_W-1:0]    rd_rate,
   output logic [PAN_W-1:0]     rd_pan,
   output logic [VOL_W-1:0]     rd_vol,
   output logic                 key_on,
   output logic                 key_off,
   output logic [VIDX_W-1:0]    key_voice
);

   localparam int PAN_MID = (1 << (PAN_W - 1)) - 1;

   // elaboration-time parameter checks
   if (SLOT_W < 1) begin : g_bad_slot
      $error("SLOT_W must be at least 1");
   end
   if (OFS_W < 7) begin : g_bad_ofs
      $error("OFS_W must cover offsets up to 0x28");
   end
   if (WIN_W < 1) begin : g_bad_win
      $error("WIN_W must be at least 1");
   end
   if (BASE_RATE <= 0 || longint'(BASE_RATE) * 2048 >= (longint'(1) << RATE_W)) begin : g_bad_rate
      $error("BASE_RATE out of range for RATE_W");
   end

   logic [HALF_W-1:0] wd;
   logic              unused_hi;
   logic [VIDX_W-1:0] dec_voice;
   vrd_fld_e          dec_fld;
   logic [RATE_W-1:0] conv_rate;
   logic [VOL_W-1:0]  conv_vol;
   logic [PAN_W-1:0]  pan_raw;
   logic [PAN_W-1:0]  pan_map;
   vrd_voice_t        view;
   logic              cfg_wr;

   assign wd        = wr_data[HALF_W-1:0];
   assign unused_hi = ^wr_data[31:HALF_W];

   vrd_addr_decode #(
      .SLOT_W (SLOT_W),
      .OFS_W  (OFS_W),
      .WIN_W  (WIN_W)
   ) u_dec (
      .win   (wr_win),
      .addr  (wr_addr),
      .voice (dec_voice),
      .fld   (dec_fld)
   );

   vrd_pitch_conv #(
      .BASE_RATE (BASE_RATE)
   ) u_pitch (
      .pitch (wd),
      .rate  (conv_rate)
   );

   vrd_vol_curve #(
      .IDX_W (VOL_W)
   ) u_vol (
      .idx (wd[VOL_W-1:0]),
      .vol (conv_vol)
   );

   // pan: lower half mirrored, upper half passed through
   assign pan_raw = wd[PAN_W-1:0];
   assign pan_map = (pan_raw <= PAN_W'(PAN_MID)) ? (PAN_W'(PAN_MID) - pan_raw) : pan_raw;

   vrd_voice_bank #(
      .VIDX_W (VIDX_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en),
      .fld     (dec_fld),
      .widx    (dec_voice),
      .wdata   (wd),
      .rate_in (conv_rate),
      .pan_in  (pan_map),
      .vol_in  (conv_vol),
      .ridx    (rd_voice),
      .rdata   (view)
   );

   assign rd_start      = view.start;
   assign rd_loop_en    = view.loop_en;
   assign rd_fmt        = view.fmt;
   assign rd_loop_start = view.loop_start;
   assign rd_end        = view.end_addr;
   assign rd_rate       = view.rate;
   assign rd_pan        = view.pan;
   assign rd_vol        = view.vol;

   // key strobes: registered one-cycle pulses
   assign cfg_wr = wr_en && (dec_fld == FLD_CFG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         key_on    <= 1'b0;
         key_off   <= 1'b0;
         key_voice <= '0;
      end else begin
         key_on  <= cfg_wr && (wd[15:14] == 2'b11);
         key_off <= cfg_wr && (wd[15:14] == 2'b10);
         if (cfg_wr) begin
            key_voice <= dec_voice;
         end
      end
   end

   p_key_exclusive_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      !(key_on && key_off));

   p_key_from_cfg_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (key_on || key_off) |-> $past(wr_en && dec_fld == FLD_CFG));

   p_key_voice_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (key_on || key_off) |-> (key_voice == $past(dec_voice)));

endmodule

// File: tb/tb_voice_reg_decoder.sv
module tb_voice_reg_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [0:0]  wr_win = '0;
   logic [11:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [5:0]  rd_voice = '0;
   logic [20:0] rd_start;
   logic        rd_loop_en;
   logic [1:0]  rd_fmt;
   logic [15:0] rd_loop_start;
   logic [15:0] rd_end;
   logic [31:0] rd_rate;
   logic [4:0]  rd_pan;
   logic [7:0]  rd_vol;
   logic        key_on;
   logic        key_off;
   logic [5:0]  key_voice;

   int checks = 0;
   int errors = 0;
   logic seen_on, seen_off;
   logic [5:0] seen_voice;

   always #5 clk = ~clk;

   voice_reg_decoder dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_voice(rd_voice),
      .rd_start(rd_start), .rd_loop_en(rd_loop_en), .rd_fmt(rd_fmt),
      .rd_loop_start(rd_loop_start), .rd_end(rd_end), .rd_rate(rd_rate),
      .rd_pan(rd_pan), .rd_vol(rd_vol), .key_on(key_on), .key_off(key_off),
      .key_voice(key_voice)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // global voice index -> window and slot, one write, then capture strobes
   task automatic wr(input int voice, input int ofs, input logic [31:0] data);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_win  = 1'(voice / 32);
      wr_addr = 12'(((voice % 32) << 7) | ofs);
      wr_data = data;
      @(negedge clk);
      wr_en      = 1'b0;
      seen_on    = key_on;
      seen_off   = key_off;
      seen_voice = key_voice;
   endtask

   task automatic sel(input int voice);
      rd_voice = 6'(voice);
      #1;
   endtask

   function automatic longint rate_ref(input int p);
      int e, m, k;
      e = (p >> 11) & 7;
      m = p & 1023;
      if ((p & 16384) != 0) begin
         k = 8 - e;
         return longint'((44100 >> k) + ((44100 * m) >> (10 + k)));
      end
      return longint'((44100 << e) + ((44100 * m) >> (10 - e)));
   endfunction

   task automatic t_reset();
      sel(0);
      chk("R11", "start v0", rd_start, 0);
      chk("R11", "rate v0", rd_rate, 0);
      sel(63);
      chk("R11", "pan v63", rd_pan, 0);
      chk("R11", "vol v63", rd_vol, 0);
      chk("R11", "key_on", key_on, 0);
      chk("R11", "key_off", key_off, 0);
   endtask

   task automatic t_decode();
      wr(37, 'h08, 32'h0000_1234);
      sel(37); chk("R1", "loop_start v37", rd_loop_start, 'h1234);
      sel(5);  chk("R12", "loop_start v5 untouched", rd_loop_start, 0);
      wr(31, 'h0C, 32'hFFFF_BEEF);
      sel(31); chk("R5", "end v31", rd_end, 'hBEEF);
      sel(63); chk("R12", "end v63 untouched", rd_end, 0);
   endtask

   task automatic t_start_cfg();
      // low half first, then config: both halves must survive
      wr(3, 'h04, 32'h0000_A5A5);
      wr(3, 'h00, 32'hABCD_0000 | 32'h0000_0215);
      sel(3);
      chk("R3", "start after cfg", rd_start, ('h15 << 16) | 'hA5A5);
      chk("R3", "loop_en", rd_loop_en, 1);
      chk("R3", "fmt 0 -> 16-bit", rd_fmt, 0);
      chk("R2", "upper data bits no key", seen_on | seen_off, 0);
      wr(3, 'h04, 32'h0000_0F0F);
      sel(3); chk("R5", "start lo keeps hi", rd_start, ('h15 << 16) | 'h0F0F);
      wr(3, 'h00, 32'h0000_0080);
      sel(3);
      chk("R3", "fmt 1 -> 8-bit", rd_fmt, 1);
      chk("R3", "loop cleared", rd_loop_en, 0);
      wr(3, 'h00, 32'h0000_0100);
      sel(3); chk("R3", "fmt 2 -> adpcm", rd_fmt, 2);
      wr(3, 'h00, 32'h0000_0180);
      sel(3); chk("R3", "fmt 3 -> adpcm", rd_fmt, 2);
   endtask

   task automatic t_keys();
      wr(44, 'h00, 32'h0000_C000);
      chk("R4", "key_on raised", seen_on, 1);
      chk("R4", "key_off low on key-on", seen_off, 0);
      chk("R4", "key_voice", seen_voice, 44);
      @(negedge clk);
      chk("R4", "key_on one cycle", key_on, 0);
      wr(9, 'h00, 32'h0000_8000);
      chk("R4", "key_off raised", seen_off, 1);
      chk("R4", "key_voice off", seen_voice, 9);
      @(negedge clk);
      chk("R4", "key_off one cycle", key_off, 0);
      wr(9, 'h00, 32'h0000_4000);
      chk("R4", "code 1 no strobe", seen_on | seen_off, 0);
      wr(9, 'h00, 32'h0000_0000);
      chk("R4", "code 0 no strobe", seen_on | seen_off, 0);
   endtask

   task automatic t_pitch();
      int pw [6] = '{'h0000, 'h3BFF, 'h0A00, 'h4000, 'h7BFF, 'hC7FF};
      for (int i = 0; i < 6; i++) begin
         wr(20, 'h18, 32'(pw[i]));
         sel(20);
         if ((pw[i] & 'h4000) != 0) chk("R7", $sformatf("rate %h", pw[i]), rd_rate, rate_ref(pw[i]));
         else chk("R6", $sformatf("rate %h", pw[i]), rd_rate, rate_ref(pw[i]));
      end
      chk("R6", "rate 0x0A00 literal", rate_ref('h0A00), 132300);
      chk("R7", "rate 0x4000 literal", rate_ref('h4000), 172);
   endtask

   task automatic t_pan();
      int v [5] = '{0, 3, 15, 16, 31};
      for (int i = 0; i < 5; i++) begin
         wr(50, 'h24, 32'(32'hE0 | v[i]));
         sel(50);
         chk("R8", $sformatf("pan v=%0d", v[i]), rd_pan, (v[i] <= 15) ? 15 - v[i] : v[i]);
      end
   endtask

   task automatic t_vol();
      int ix [5] = '{0, 1, 16, 128, 255};
      for (int i = 0; i < 5; i++) begin
         wr(60, 'h28, 32'(32'h1F00 | ix[i]));
         sel(60);
         chk("R9", $sformatf("vol i=%0d", ix[i]), rd_vol, (ix[i] * (ix[i] + 1)) >> 8);
      end
   endtask

   task automatic t_ignore();
      int ofs [5] = '{'h10, 'h14, 'h1C, 'h20, 'h01};
      wr(12, 'h0C, 32'h0000_7777);
      wr(12, 'h24, 32'h0000_0014);
      for (int i = 0; i < 5; i++) begin
         wr(12, ofs[i], 32'h0000_FFFF);
         chk("R10", $sformatf("no strobe ofs %h", ofs[i]), seen_on | seen_off, 0);
      end
      sel(12);
      chk("R10", "end kept", rd_end, 'h7777);
      chk("R10", "pan kept", rd_pan, 20);
      chk("R10", "start kept", rd_start, 0);
      chk("R10", "rate kept", rd_rate, 0);
      chk("R10", "vol kept", rd_vol, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_decode();
      t_start_cfg();
      t_keys();
      t_pitch();
      t_pan();
      t_vol();
      t_ignore();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule